// File: doc/BRIEF.md
# Floating-Point Register Stack Fault Detector

This block keeps the bookkeeping state of an eight-entry floating-point register stack: a 3-bit top pointer and, for each physical register, one bit that says whether the register is empty. Each cycle the block accepts at most one request. A request is a push, a pop or an operand read, and a pop or a read names a register relative to the top. The block decides whether the request faults. A push into an occupied slot is an overflow. A pop or read that touches an empty register is an underflow.

When a request faults, the block records the fault in a 16-bit status word. It sets the sticky invalid-operation and stack-fault flags and drives condition bit C1 to tell overflow from underflow. It also raises a one-cycle exception pulse unless the invalid-operation mask is set. A faulting request leaves the pointer and the tags unchanged. A successful request moves the pointer and updates the tags. A whole tag word can also be loaded. Each 2-bit code in it is reduced to empty or occupied.

Top module: `fpstk_fault_unit`

## Requirements
- R1: After reset, the status word is 0x0000, all eight registers read as empty (reg_empty_o = 8'hFF) and unmasked_exc_o is 0.
- R2: A request that faults sets status bit 0 (invalid operation) one cycle later.
- R3: A request that faults sets status bit 6 (stack fault) one cycle later.
- R4: A fault drives status bit 9 (C1) to 1 for an overflow and to 0 for an underflow. C1 otherwise holds its value, and clr_exc_i clears it.
- R5: op_i encodes 0 as none, 1 as push, 2 as pop and 3 as read. ST(i) is physical register (top + i) mod 8. A push whose target, physical register (top - 1) mod 8, is occupied is an overflow.
- R6: A pop is an underflow when ST(0) or ST(idx_i) is empty. A read is an underflow when ST(idx_i) is empty.
- R7: A successful push decrements the top modulo 8 and marks its target occupied. A successful pop marks ST(0) empty and increments the top modulo 8. A successful read changes no state.
- R8: A faulting request leaves the top pointer and every tag unchanged.
- R9: The status word carries the top pointer in bits 13:11. Bits 15:14, 10, 8:7 and 5:1 read as 0.
- R10: Bits 0 and 6 stay set until a cycle with clr_exc_i high. If a fault occurs in that same cycle, the fault wins.
- R11: When tag_load_i is high, field i (bits 2i+1:2i) of tag_word_i sets physical register i. The code 11 means empty and any other code means occupied. The request on op_i is ignored in that cycle.
- R12: A fault with inv_mask_i low raises unmasked_exc_o for exactly the next cycle. With inv_mask_i high it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Request: 0 none, 1 push, 2 pop, 3 read |
| idx_i | input | 3 | Stack-relative register index for pop and read |
| tag_load_i | input | 1 | Load the full tag word this cycle |
| tag_word_i | input | 16 | Tag word, 2 bits per physical register |
| clr_exc_i | input | 1 | Clear the sticky invalid, stack-fault and C1 bits |
| inv_mask_i | input | 1 | Invalid-operation mask (1 = masked) |
| status_o | output | 16 | Status word |
| unmasked_exc_o | output | 1 | One-cycle unmasked exception pulse |
| reg_empty_o | output | 8 | Per physical register empty flag |

## Verification
Directed sequences fill the stack with eight pushes and then push a ninth time. This separates the overflow path, and the C1 = 1 value it sets, from a correct wrap of the pointer. Pops from an emptied stack and reads of a distant ST(i) test the underflow paths. They also show whether C1 returns to 0 and whether the pointer and tags stay frozen. A tag load that mixes all four codes shows whether only code 11 counts as empty and whether a request in the same cycle is ignored. Random mixes of all request types, indices, clears and mask settings then check the stickiness, the clear-versus-fault priority and the mask against a model of the stack kept in the bench.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int unsigned STK_DEPTH = 8;
  localparam int unsigned STK_PTR_W = $clog2(STK_DEPTH);
  localparam int unsigned SW_W      = 16;
  localparam int unsigned SW_IE_BIT = 0;
  localparam int unsigned SW_SF_BIT = 6;
  localparam int unsigned SW_C1_BIT = 9;
  localparam int unsigned SW_TOP_LO = 11;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_READ = 2'd3
  } stk_op_e;
endpackage

// File: rtl/fpstk_fault.sv
module fpstk_fault
  import fpstk_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  stk_op_e          op_i,
  input  logic [PW-1:0]    idx_i,
  input  logic             tag_load_i,
  input  logic [PW-1:0]    top_i,
  input  logic [DEPTH-1:0] empty_i,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             fault_o
);
  logic [PW-1:0] st0_idx;
  logic [PW-1:0] sti_idx;
  logic [PW-1:0] push_idx;

  always_comb begin
    st0_idx  = top_i;
    sti_idx  = top_i + idx_i;
    push_idx = top_i - 1'b1;
    ovf_o    = 1'b0;
    unf_o    = 1'b0;
    if (!tag_load_i) begin
      unique case (op_i)
        OP_PUSH: ovf_o = !empty_i[push_idx];
        OP_POP:  unf_o = empty_i[st0_idx] || empty_i[sti_idx];
        OP_READ: unf_o = empty_i[sti_idx];
        default: ;
      endcase
    end
    fault_o = ovf_o || unf_o;
  end
endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags
  import fpstk_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stk_op_e            op_i,
  input  logic               tag_load_i,
  input  logic [2*DEPTH-1:0] tag_word_i,
  input  logic               fault_i,
  output logic [PW-1:0]      top_o,
  output logic [DEPTH-1:0]   empty_o
);
  logic [PW-1:0]    top_q, top_n;
  logic [DEPTH-1:0] empty_q, empty_n;
  logic [DEPTH-1:0] load_empty;
  logic             upd_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_decode
    assign load_empty[g] = &tag_word_i[2*g+1 -: 2];
  end

  always_comb begin
    top_n   = top_q;
    empty_n = empty_q;
    upd_en  = 1'b0;
    if (tag_load_i) begin
      empty_n = load_empty;
      upd_en  = 1'b1;
    end else if (!fault_i) begin
      unique case (op_i)
        OP_PUSH: begin
          top_n          = top_q - 1'b1;
          empty_n[top_n] = 1'b0;
          upd_en         = 1'b1;
        end
        OP_POP: begin
          empty_n[top_q] = 1'b1;
          top_n          = top_q + 1'b1;
          upd_en         = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      empty_q <= '1;
    end else if (upd_en) begin
      top_q   <= top_n;
      empty_q <= empty_n;
    end
  end

  assign top_o   = top_q;
  assign empty_o = empty_q;

  assert_fault_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> ($stable(top_q) && $stable(empty_q)));

  assert_push_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH && !fault_i && !tag_load_i) |=>
      (top_q == PW'($past(top_q) - 1'b1) && !empty_q[top_q]));

  assert_pop_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_POP && !fault_i && !tag_load_i) |=>
      (top_q == PW'($past(top_q) + 1'b1)));
endmodule

// File: rtl/fpstk_status.sv
module fpstk_status
  import fpstk_pkg::*;
#(
  parameter int unsigned PW = STK_PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_i,
  input  logic          ovf_i,
  input  logic          clr_i,
  input  logic          mask_i,
  input  logic [PW-1:0] top_i,
  output logic [SW_W-1:0] status_o,
  output logic          unm_o
);
  logic ie_q, ie_n;
  logic sf_q, sf_n;
  logic c1_q, c1_n;
  logic unm_q, unm_n;

  always_comb begin
    ie_n  = fault_i || (ie_q && !clr_i);
    sf_n  = fault_i || (sf_q && !clr_i);
    if (fault_i)     c1_n = ovf_i;
    else if (clr_i)  c1_n = 1'b0;
    else             c1_n = c1_q;
    unm_n = fault_i && !mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      sf_q  <= 1'b0;
      c1_q  <= 1'b0;
      unm_q <= 1'b0;
    end else begin
      ie_q  <= ie_n;
      sf_q  <= sf_n;
      c1_q  <= c1_n;
      unm_q <= unm_n;
    end
  end

  always_comb begin
    status_o                        = '0;
    status_o[SW_IE_BIT]             = ie_q;
    status_o[SW_SF_BIT]             = sf_q;
    status_o[SW_C1_BIT]             = c1_q;
    status_o[SW_TOP_LO +: PW]       = top_i;
  end
  assign unm_o = unm_q;

  assert_ie_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> status_o[SW_IE_BIT]);
  assert_sf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> status_o[SW_SF_BIT]);
  assert_c1_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && ovf_i) |=> status_o[SW_C1_BIT]);
  assert_c1_unf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && !ovf_i) |=> !status_o[SW_C1_BIT]);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[SW_IE_BIT] && !clr_i) |=> status_o[SW_IE_BIT]);
  assert_unmasked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && !mask_i) |=> unm_o);
  assert_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> !unm_o);
endmodule

// File: rtl/fpstk_fault_unit.sv
module fpstk_fault_unit
  import fpstk_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         op_i,
  input  logic [PW-1:0]      idx_i,
  input  logic               tag_load_i,
  input  logic [2*DEPTH-1:0] tag_word_i,
  input  logic               clr_exc_i,
  input  logic               inv_mask_i,
  output logic [SW_W-1:0]    status_o,
  output logic               unmasked_exc_o,
  output logic [DEPTH-1:0]   reg_empty_o
);
  stk_op_e          op;
  logic [PW-1:0]    top;
  logic [DEPTH-1:0] empty;
  logic             ovf, unf, fault;

  assign op = stk_op_e'(op_i);

  fpstk_fault #(.DEPTH(DEPTH)) u_fault (
    .op_i       (op),
    .idx_i      (idx_i),
    .tag_load_i (tag_load_i),
    .top_i      (top),
    .empty_i    (empty),
    .ovf_o      (ovf),
    .unf_o      (unf),
    .fault_o    (fault)
  );

  fpstk_tags #(.DEPTH(DEPTH)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .tag_load_i (tag_load_i),
    .tag_word_i (tag_word_i),
    .fault_i    (fault),
    .top_o      (top),
    .empty_o    (empty)
  );

  fpstk_status #(.PW(PW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_i  (fault),
    .ovf_i    (ovf),
    .clr_i    (clr_exc_i),
    .mask_i   (inv_mask_i),
    .top_i    (top),
    .status_o (status_o),
    .unm_o    (unmasked_exc_o)
  );

  assign reg_empty_o = empty;

  assert_no_dual_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
  assert_overflow_only_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (status_o[SW_C1_BIT] && status_o[SW_TOP_LO +: PW] == $past(top)));
endmodule

// File: tb/fpstk_fault_unit_tb.sv
module fpstk_fault_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op_i;
  logic [2:0]  idx_i;
  logic        tag_load_i;
  logic [15:0] tag_word_i;
  logic        clr_exc_i;
  logic        inv_mask_i;
  logic [15:0] status_o;
  logic        unmasked_exc_o;
  logic [7:0]  reg_empty_o;

  int n_chk = 0;
  int n_err = 0;

  logic [2:0] m_top;
  logic [7:0] m_empty;
  logic       m_ie, m_sf, m_c1, m_unm;

  always #4 clk = ~clk;

  fpstk_fault_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i),
    .tag_load_i(tag_load_i), .tag_word_i(tag_word_i),
    .clr_exc_i(clr_exc_i), .inv_mask_i(inv_mask_i),
    .status_o(status_o), .unmasked_exc_o(unmasked_exc_o),
    .reg_empty_o(reg_empty_o)
  );

  function automatic logic [15:0] exp_status();
    return {2'b00, m_top, 1'b0, m_c1, 2'b00, m_sf, 5'b00000, m_ie};
  endfunction

  function automatic logic [7:0] decode_tags(input logic [15:0] w);
    logic [7:0] e;
    for (int i = 0; i < 8; i++) e[i] = (w[2*i +: 2] == 2'b11);
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [2:0] idx, input logic ld,
                      input logic [15:0] w, input logic clr, input logic msk, input string tag);
    logic ovf, unf, flt;
    logic [2:0] sti, pslot;
    @(negedge clk);
    op_i = op; idx_i = idx; tag_load_i = ld; tag_word_i = w;
    clr_exc_i = clr; inv_mask_i = msk;
    sti   = m_top + idx;
    pslot = m_top - 3'd1;
    ovf = !ld && op == 2'd1 && !m_empty[pslot];
    unf = !ld && ((op == 2'd2 && (m_empty[m_top] || m_empty[sti])) ||
                  (op == 2'd3 && m_empty[sti]));
    flt = ovf || unf;
    if (ld) m_empty = decode_tags(w);
    else if (!flt) begin
      if (op == 2'd1) begin m_top = pslot; m_empty[m_top] = 1'b0; end
      else if (op == 2'd2) begin m_empty[m_top] = 1'b1; m_top = m_top + 3'd1; end
    end
    m_ie = flt || (m_ie && !clr);
    m_sf = flt || (m_sf && !clr);
    m_c1 = flt ? ovf : (clr ? 1'b0 : m_c1);
    m_unm = flt && !msk;
    @(posedge clk); #2;
    check({tag, " status"}, {16'h0, status_o}, {16'h0, exp_status()});
    check({tag, " tags"}, {24'h0, reg_empty_o}, {24'h0, m_empty});
    check({tag, " pulse R12"}, {31'h0, unmasked_exc_o}, {31'h0, m_unm});
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; op_i = 0; idx_i = 0; tag_load_i = 0; tag_word_i = 0;
    clr_exc_i = 0; inv_mask_i = 0;
    m_top = 0; m_empty = 8'hFF; m_ie = 0; m_sf = 0; m_c1 = 0; m_unm = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset status", {16'h0, status_o}, 32'h0);
    check("R1 reset tags", {24'h0, reg_empty_o}, 32'hFF);
    check("R1 reset pulse", {31'h0, unmasked_exc_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R6 underflow on empty stack: pop and read
    step(2'd2, 3'd0, 0, 16'h0, 0, 0, "R6 R2 R3 R4 pop empty");
    step(2'd0, 3'd0, 0, 16'h0, 0, 0, "R12 pulse ends");
    step(2'd3, 3'd5, 0, 16'h0, 0, 1, "R6 R8 read empty masked");
    step(2'd0, 3'd0, 0, 16'h0, 1, 0, "R10 clear");
    // R7 fill the stack, R5 overflow on ninth push
    for (int i = 0; i < 8; i++) step(2'd1, 3'd0, 0, 16'h0, 0, 0, "R7 R9 push");
    step(2'd1, 3'd0, 0, 16'h0, 0, 0, "R5 R4 R8 overflow");
    step(2'd0, 3'd0, 0, 16'h0, 0, 0, "R10 sticky");
    step(2'd3, 3'd7, 0, 16'h0, 1, 0, "R7 read ok and clear");
    step(2'd2, 3'd0, 0, 16'h0, 0, 0, "R7 pop");
    step(2'd2, 3'd7, 0, 16'h0, 1, 0, "R6 R10 pop idx empty vs clear");
    // R11 load with mixed codes; op ignored
    step(2'd1, 3'd0, 1, 16'b11_10_01_00_11_11_00_10, 0, 0, "R11 load");
    step(2'd3, 3'd3, 0, 16'h0, 0, 0, "R11 R6 read after load");
    step(2'd2, 3'd0, 1, 16'hFFFF, 1, 0, "R11 load all empty");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op;
      logic ld;
      op = 2'($urandom_range(0, 3));
      ld = ($urandom_range(0, 31) == 0);
      step(op, 3'($urandom), ld, 16'($urandom), ($urandom_range(0, 15) == 0),
           1'($urandom), "R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule